// File: doc/BRIEF.md
# Serial ADC Command Front End

This block is the device-side digital serial port of an eight-input, 10-bit converter. It oversamples chip select, serial clock and serial data in with the system clock. It finds the start bit that opens a command and collects the rest of the 8-bit control word. It then gives the input-select, polarity, input-type and power fields to a conversion source. That source is a stub outside the block and returns a 10-bit code on a parallel input. The block sends that code back, most significant bit first, on serial data out. The serial clock is the only timebase for a conversion.

Capturing a command and reading out a result run as two separate machines. A new command can therefore begin while the previous result is still being shifted out. With chip select held low, a new conversion can start every 15 serial clocks. Raising chip select abandons whatever is in flight. A run of zeros on serial data in always brings the port back to a state where it is looking for a start bit.

Each serial clock phase must last at least two system clock cycles. Data in is taken on serial clock rising edges. Data out changes on falling edges and settles within two system clocks of the edge.

Top module: `adc_serial_front`

## Requirements
- R1: While no result readout is blocking it and `cs_n` is low, the first `din` = 1 seen at a `sclk` rising edge is taken as a start bit and opens a command.
- R2: After the start bit, the next seven rising edges deliver, in order: `conv_chan[2]`, `conv_chan[1]`, `conv_chan[0]`, `conv_unipolar`, `conv_single`, `conv_pwr[1]`, `conv_pwr[0]`. The power-mode LSB is therefore the last bit clocked in. The fields update together, and `conv_req` pulses for one clock after the eighth rising edge.
- R3: On the first falling edge after the eighth rising edge, `dout` is driven to 0 (a null slot), and `conv_code` is sampled on that edge. The next ten falling edges drive `conv_code[9]` down to `conv_code[0]`. Every later falling edge drives 0.
- R4: During a readout, `din` = 1 is ignored until the falling edge that drives result bit 3. The earliest new start bit is therefore the 15th rising edge after the previous start bit, and periods of 15 and 16 clocks both work.
- R5: `cs_n` high abandons a command being captured (no `conv_req`) or a result being read out. After that, `dout` stays 0 until a new result, and the first `din` = 1 after `cs_n` returns low is a start bit.
- R6: From reset until a first result is read out, `dout` is 0 and `conv_req` stays low.
- R7: With `cs_n` held low and `sclk` running, sixteen consecutive zeros on `din` leave the port looking for a start bit, whatever its state before them.
- R8: `dout_oe` is 0 while `cs_n` is high and 1 while it is low, with a delay of one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data |
| conv_code | input | CODE_W | Result from the conversion source |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` (0 models high impedance) |
| conv_req | output | 1 | One-clock pulse when a command is complete |
| conv_chan | output | CHAN_W | Selected input |
| conv_unipolar | output | 1 | Polarity bit of the command |
| conv_single | output | 1 | Single-ended / differential bit |
| conv_pwr | output | PWR_W | Power-mode field |

## Verification
The bench builds the block with its defaults: a 10-bit code, three select bits, two power bits, and re-arming after result bit 3. This puts the earliest restart at index 15 of a bit stream. The bench sets one code per input in a table, so each readout word also shows which select field the stub received. Streams place stray ones in the blocked window and test periods of 15 and 16 clocks and random longer gaps. They also drop chip select part-way through both the command and the readout.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

    typedef enum logic [1:0] {
        CT_HUNT = 2'd0,
        CT_CTRL = 2'd1,
        CT_WAIT = 2'd2
    } ctl_state_e;

    // bits of the command that follow the start bit
    function automatic int body_width(input int chan_w, input int pwr_w);
        return chan_w + 2 + pwr_w;
    endfunction

endpackage

// File: rtl/adc_fe_sampler.sv
module adc_fe_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic din,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_n_s,
    output logic din_s
);

    typedef struct packed {
        logic sclk;
        logic sclk_prev;
        logic cs_n;
        logic din;
    } smp_t;

    smp_t q, d;

    always_comb begin
        d           = q;
        d.sclk      = sclk;
        d.sclk_prev = q.sclk;
        d.cs_n      = cs_n;
        d.din       = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk_rise = q.sclk & ~q.sclk_prev & ~q.cs_n;
    assign sclk_fall = ~q.sclk & q.sclk_prev & ~q.cs_n;
    assign cs_n_s    = q.cs_n;
    assign din_s     = q.din;

endmodule

// File: rtl/adc_fe_ctrl.sv
module adc_fe_ctrl
    import adc_fe_pkg::*;
#(
    parameter int CHAN_W = 3,
    parameter int PWR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              cs_n_s,
    input  logic              din_s,
    input  logic              rearm,
    output logic              load,
    output logic [CHAN_W-1:0] chan,
    output logic              unipolar,
    output logic              single,
    output logic [PWR_W-1:0]  pwr
);

    localparam int BODY_W = body_width(CHAN_W, PWR_W);
    localparam int CNT_W  = $clog2(BODY_W + 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [CNT_W-1:0]  bitcnt;
        logic [BODY_W-2:0] sreg;
        logic [CHAN_W-1:0] chan;
        logic              unipolar;
        logic              single;
        logic [PWR_W-1:0]  pwr;
    } ctl_t;

    ctl_t q, d;
    logic [BODY_W-1:0] nxt_body;

    always_comb begin
        d        = q;
        load     = 1'b0;
        nxt_body = {q.sreg, din_s};
        if (cs_n_s) begin
            d.st     = CT_HUNT;
            d.bitcnt = '0;
        end else begin
            unique case (q.st)
                CT_HUNT: begin
                    if (sclk_rise && din_s && rearm) begin
                        d.st     = CT_CTRL;
                        d.bitcnt = '0;
                    end
                end
                CT_CTRL: begin
                    if (sclk_rise) begin
                        d.sreg   = nxt_body[BODY_W-2:0];
                        d.bitcnt = q.bitcnt + 1'b1;
                        if (q.bitcnt == CNT_W'(BODY_W - 1)) begin
                            load       = 1'b1;
                            d.st       = CT_WAIT;
                            d.chan     = nxt_body[BODY_W-1 -: CHAN_W];
                            d.unipolar = nxt_body[PWR_W+1];
                            d.single   = nxt_body[PWR_W];
                            d.pwr      = nxt_body[PWR_W-1:0];
                        end
                    end
                end
                CT_WAIT: begin
                    if (rearm) begin
                        d.st = CT_HUNT;
                    end
                end
                default: d.st = CT_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign chan     = q.chan;
    assign unipolar = q.unipolar;
    assign single   = q.single;
    assign pwr      = q.pwr;

    // R5: deselect always returns the capture machine to hunting
    a_r5_deselect_hunts: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (q.st == CT_HUNT));

    // R4: a blocked machine cannot start a new command before re-arm
    a_r4_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == CT_WAIT && !rearm) |=> (q.st != CT_CTRL));

    // R2: a completed command always parks the machine until re-arm
    a_r2_load_parks: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q.st == CT_WAIT));

endmodule

// File: rtl/adc_fe_shifter.sv
module adc_fe_shifter #(
    parameter int CODE_W    = 10,
    parameter int REARM_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_fall,
    input  logic              cs_n_s,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    output logic              dout,
    output logic              rearm
);

    // falling-edge count after which a given result bit is on the pin
    localparam int FILL_IDX  = CODE_W + 2;
    localparam int REARM_IDX = CODE_W + 1 - REARM_BIT;
    localparam int FC_W      = $clog2(FILL_IDX + 1);

    typedef struct packed {
        logic              active;
        logic              pending;
        logic [FC_W-1:0]   fcnt;
        logic [CODE_W-1:0] shreg;
        logic              dout;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        if (cs_n_s) begin
            d.active  = 1'b0;
            d.pending = 1'b0;
            d.fcnt    = '0;
            d.shreg   = '0;
            d.dout    = 1'b0;
        end else if (load) begin
            d.active  = 1'b1;
            d.pending = 1'b1;
            d.fcnt    = '0;
        end else if (sclk_fall && q.active) begin
            if (q.pending) begin
                d.pending = 1'b0;
                d.shreg   = code;
                d.dout    = 1'b0;
                d.fcnt    = FC_W'(1);
            end else begin
                d.dout  = q.shreg[CODE_W-1];
                d.shreg = q.shreg << 1;
                if (q.fcnt != FC_W'(FILL_IDX)) begin
                    d.fcnt = q.fcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dout  = q.dout;
    assign rearm = !q.active || (!q.pending && (q.fcnt >= FC_W'(REARM_IDX)));

    // R6: no result in flight means a quiet data line
    a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !q.active |-> !q.dout);

    // R3: the first falling edge of a readout is the null slot
    a_r3_null_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && q.active && q.pending && !cs_n_s && !load)
            |=> (q.fcnt == FC_W'(1) && !q.dout));

    // R3: each later falling edge advances the bit position by one
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && q.active && !q.pending && !cs_n_s && !load
            && q.fcnt != FC_W'(FILL_IDX))
            |=> (q.fcnt == $past(q.fcnt) + 1'b1));

endmodule

// File: rtl/adc_serial_front.sv
module adc_serial_front #(
    parameter int CODE_W    = 10,
    parameter int CHAN_W    = 3,
    parameter int PWR_W     = 2,
    parameter int REARM_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic [CODE_W-1:0] conv_code,
    output logic              dout,
    output logic              dout_oe,
    output logic              conv_req,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              conv_unipolar,
    output logic              conv_single,
    output logic [PWR_W-1:0]  conv_pwr
);

    logic sclk_rise, sclk_fall, cs_n_s, din_s;
    logic load, rearm;

    typedef struct packed {
        logic req;
    } top_t;

    top_t q, d;

    adc_fe_sampler u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .din       (din),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_n_s    (cs_n_s),
        .din_s     (din_s)
    );

    adc_fe_ctrl #(
        .CHAN_W (CHAN_W),
        .PWR_W  (PWR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .cs_n_s    (cs_n_s),
        .din_s     (din_s),
        .rearm     (rearm),
        .load      (load),
        .chan      (conv_chan),
        .unipolar  (conv_unipolar),
        .single    (conv_single),
        .pwr       (conv_pwr)
    );

    adc_fe_shifter #(
        .CODE_W    (CODE_W),
        .REARM_BIT (REARM_BIT)
    ) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_fall (sclk_fall),
        .cs_n_s    (cs_n_s),
        .load      (load),
        .code      (conv_code),
        .dout      (dout),
        .rearm     (rearm)
    );

    always_comb begin
        d     = q;
        d.req = load;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign conv_req = q.req;
    assign dout_oe  = ~cs_n_s;

    // R2: a request only follows a serial clock rising edge
    a_r2_req_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> $past(sclk_rise));

    // R8: deselect at the pin turns the driver off on the next clock
    a_r8_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !dout_oe);

    // R5: deselect forces the data line low one clock after it is seen
    a_r5_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !dout);

endmodule

// File: tb/tb_adc_serial_front.sv
module tb_adc_serial_front;

    localparam int CODE_W = 10;
    localparam int CHAN_W = 3;
    localparam int PWR_W  = 2;
    localparam int HALF   = 3;
    localparam int MAXN   = 256;
    localparam int MAXF   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic din = 1'b0;
    logic [CODE_W-1:0] conv_code;
    logic dout, dout_oe, conv_req, conv_unipolar, conv_single;
    logic [CHAN_W-1:0] conv_chan;
    logic [PWR_W-1:0]  conv_pwr;

    logic [CODE_W-1:0] code_tab [8];
    assign conv_code = code_tab[conv_chan];

    always #10 clk = ~clk;

    adc_serial_front dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .sclk          (sclk),
        .din           (din),
        .conv_code     (conv_code),
        .dout          (dout),
        .dout_oe       (dout_oe),
        .conv_req      (conv_req),
        .conv_chan     (conv_chan),
        .conv_unipolar (conv_unipolar),
        .conv_single   (conv_single),
        .conv_pwr      (conv_pwr)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // request log
    logic       log_clear = 1'b1;
    int         nlog;
    logic [6:0] log_bits [MAXF];
    always @(posedge clk) begin
        if (log_clear) nlog <= 0;
        else if (conv_req) begin
            if (nlog < MAXF) log_bits[nlog] <= {conv_chan, conv_unipolar, conv_single, conv_pwr};
            nlog <= nlog + 1;
        end
    end

    // stream description and expectations
    int   slen, nfr;
    logic din_arr [MAXN];
    logic cs_arr  [MAXN];
    logic exp_arr [MAXN];
    logic dout_arr[MAXN];
    logic oe_arr  [MAXN];
    int   fs   [MAXF];
    logic [6:0] fb [MAXF];
    bit   fconv[MAXF];
    bit   ffull[MAXF];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic void clear_stream(input int len);
        for (int i = 0; i < MAXN; i++) begin
            din_arr[i] = 1'b0; cs_arr[i] = 1'b0; exp_arr[i] = 1'b0;
            dout_arr[i] = 1'b0; oe_arr[i] = 1'b0;
        end
        slen = len;
        nfr  = 0;
    endfunction

    function automatic void add_frame(input int s, input logic [6:0] b);
        logic [CODE_W-1:0] c;
        c = code_tab[b[6:4]];
        din_arr[s] = 1'b1;
        for (int k = 0; k < 7; k++) din_arr[s+1+k] = b[6-k];
        for (int j = 0; j < CODE_W; j++) exp_arr[s+9+j] = c[CODE_W-1-j];
        fs[nfr] = s; fb[nfr] = b; fconv[nfr] = 1'b1; ffull[nfr] = 1'b1;
        nfr++;
    endfunction

    function automatic void add_abort(input int a, input int len);
        for (int i = a; i < MAXN; i++) begin
            exp_arr[i] = 1'b0;
            din_arr[i] = 1'b0;
        end
        for (int i = a; i < a + len; i++) cs_arr[i] = 1'b1;
        for (int f = 0; f < nfr; f++) begin
            if (fs[f] + 7 >= a)  fconv[f] = 1'b0;
            if (fs[f] + 18 >= a) ffull[f] = 1'b0;
        end
    endfunction

    task automatic play();
        log_clear = 1'b1;
        @(negedge clk);
        log_clear = 1'b0;
        for (int i = 0; i < slen; i++) begin
            cs_n = cs_arr[i];
            din  = din_arr[i];
            repeat (HALF) @(negedge clk);
            dout_arr[i] = dout;
            oe_arr[i]   = dout_oe;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        din = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic verify(input string rq_line, input string rq_cnt);
        int bad, badi, ncv, k;
        logic [CODE_W-1:0] w, c;
        // result words of frames read out in full
        for (int f = 0; f < nfr; f++) begin
            if (ffull[f]) begin
                for (int j = 0; j < CODE_W; j++) w[CODE_W-1-j] = dout_arr[fs[f]+9+j];
                c = code_tab[fb[f][6:4]];
                check(w === c, "R3 result word", int'(w), int'(c));
            end
        end
        // every sample of the data line
        bad = 0; badi = 0;
        for (int i = 0; i < slen; i++) begin
            if (dout_arr[i] !== exp_arr[i]) begin
                if (bad == 0) badi = i;
                bad++;
            end
        end
        check(bad == 0, rq_line, int'(dout_arr[badi]), int'(exp_arr[badi]));
        // output enable against chip select (R8)
        bad = 0; badi = 0;
        for (int i = 0; i < slen; i++) begin
            if (oe_arr[i] !== !cs_arr[i]) begin
                if (bad == 0) badi = i;
                bad++;
            end
        end
        check(bad == 0, "R8 dout_oe", int'(oe_arr[badi]), int'(!cs_arr[badi]));
        // requests: count and fields
        ncv = 0;
        for (int f = 0; f < nfr; f++) if (fconv[f]) ncv++;
        check(nlog == ncv, rq_cnt, nlog, ncv);
        k = 0;
        for (int f = 0; f < nfr; f++) begin
            if (fconv[f]) begin
                if (k < nlog && k < MAXF)
                    check(log_bits[k] === fb[f], "R2 command fields", int'(log_bits[k]), int'(fb[f]));
                k++;
            end
        end
    endtask

    task automatic new_codes();
        for (int c = 0; c < 8; c++) code_tab[c] = CODE_W'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int s;
        logic [6:0] b;
        void'($urandom(32'd20240611));
        new_codes();

        // reset state (R6, R8)
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        log_clear = 1'b0;
        repeat (3) @(negedge clk);
        check(dout === 1'b0, "R6 dout after reset", int'(dout), 0);
        check(dout_oe === 1'b0, "R8 dout_oe after reset", int'(dout_oe), 0);
        check(nlog == 0, "R6 no request after reset", nlog, 0);

        // zeros with chip select low: nothing happens (R6)
        clear_stream(40);
        play();
        verify("R6 zeros before first result", "R6 no request");

        // one command opened from idle (R1, R2, R3)
        new_codes();
        clear_stream(30);
        add_frame(3, 7'b1010111);
        play();
        verify("R3 single readout", "R1 idle start");

        // power-mode bit order, last bit is pwr[0] (R2)
        clear_stream(45);
        add_frame(0, 7'b0110001);
        add_frame(20, 7'b1000010);
        play();
        verify("R3 pwr frames", "R2 pwr order");

        // 15-clock cycle with stray ones in the blocked window (R4)
        new_codes();
        clear_stream(70);
        add_frame(0, 7'b0011011);
        din_arr[14] = 1'b1;
        add_frame(15, 7'b1111100);
        din_arr[29] = 1'b1;
        din_arr[25] = 1'b1;
        add_frame(30, 7'b0100110);
        add_frame(45, 7'b1100001);
        play();
        verify("R4 15-clock readout", "R4 15-clock requests");

        // 16-clock cycle (R4)
        new_codes();
        clear_stream(60);
        add_frame(0, 7'b0010011);
        add_frame(16, 7'b1011110);
        add_frame(32, 7'b0111001);
        play();
        verify("R4 16-clock readout", "R4 16-clock requests");

        // stray start then sixteen zeros, then a real command (R7)
        new_codes();
        clear_stream(45);
        add_frame(0, 7'b0000000);
        add_frame(17, 7'b1101011);
        play();
        verify("R7 recovery readout", "R7 recovery requests");

        // garbage command then sixteen zeros (R7)
        clear_stream(50);
        add_frame(0, 7'b1111111);
        add_frame(24, 7'b0101010);
        play();
        verify("R7 garbage readout", "R7 garbage requests");

        // deselect during command capture (R5)
        new_codes();
        clear_stream(40);
        add_frame(2, 7'b1110111);
        add_abort(6, 3);
        add_frame(12, 7'b0100101);
        play();
        verify("R5 capture abort line", "R5 capture abort requests");

        // deselect during readout (R5)
        new_codes();
        clear_stream(45);
        add_frame(0, 7'b0011111);
        add_abort(12, 2);
        add_frame(16, 7'b1001100);
        play();
        verify("R5 readout abort line", "R5 readout abort requests");

        // random streams
        for (int r = 0; r < 20; r++) begin
            new_codes();
            clear_stream(MAXN);
            s = int'($urandom % 4);
            for (int f = 0; f < 4; f++) begin
                b = 7'($urandom);
                add_frame(s, b);
                if ($urandom % 2 == 0) din_arr[s + 9 + int'($urandom % 6)] = 1'b1;
                if (f < 3) s = s + 15 + int'($urandom % 6);
            end
            slen = s + 22;
            play();
            verify("R4 random readout", "R1 random requests");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule